// File: doc/BRIEF.md
# Serial divider-word loader for a frequency synthesizer

This block takes a three-wire serial stream (serial clock, serial data, latch strobe) and turns it into the parallel divider settings of a PLL frequency synthesizer. Bits enter one shared shift register on each rising edge of the serial clock, most significant bit first. A rising edge on the strobe then copies the shift register into one of two holding registers. The last bit shifted in is a control bit, and it picks which register receives the word.

A 19-bit word with control bit 0 programs the main divider: an 11-bit programmable count and a 7-bit swallow count. A 16-bit word with control bit 1 programs the reference side: a 14-bit reference count and a prescaler-select bit. The three serial inputs are asynchronous to the block clock. They pass through a synchronizer, and their edges are detected inside the block. The outputs change only when the strobe is detected. A status output stays high from reset until the first word has been latched.

Top module: `serial_loader`

## Requirements
- R1: After reset all divider outputs are zero and `unprogrammed` is 1.
- R2: A bit on `ser_data` is captured on each rising edge of `ser_clk`, most significant bit first. The control bit is the last bit captured.
- R3: On a strobe with control bit 0, `swallow_cnt` takes the 7 bits shifted just before the control bit, and `prog_cnt` takes the 11 bits shifted before those. The first bit of the 19-bit word is bit 10 of `prog_cnt`.
- R4: On a strobe with control bit 1, `ref_cnt` takes the 14 bits shifted just before the control bit, and `presc_sel` takes the bit shifted before those. That bit is the first bit of the 16-bit word.
- R5: Shifting bits while the strobe stays low leaves every output unchanged.
- R6: A strobe that loads one holding register leaves the other holding register unchanged.
- R7: `unprogrammed` falls on the first strobe after reset and stays low until the next reset.
- R8: Only the most recently shifted bits are used. Earlier extra bits are discarded.
- R9: Only a rising edge of `ser_le` loads a register. Holding it high while shifting, or letting it fall, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Latch strobe, asynchronous |
| swallow_cnt | output | 7 | Main divider swallow count |
| prog_cnt | output | 11 | Main divider programmable count |
| ref_cnt | output | 14 | Reference divider count |
| presc_sel | output | 1 | Prescaler ratio select |
| unprogrammed | output | 1 | High until the first word is latched |

## Verification
The assertions assume that the serial inputs are slow compared with `clk`. Each level of `ser_clk` and `ser_le` must last at least three block clocks, and `ser_data` must be stable across the detected serial-clock edge. Under that assumption, every edge is seen exactly once after the synchronizer. The bench holds every serial phase for four block clocks and changes inputs only at falling edges of `clk`. It also moves data only while the serial clock is low.

// File: rtl/serial_loader.sv
module serial_loader #(
  parameter int SWALLOW_W   = 7,
  parameter int PROG_W      = 11,
  parameter int REF_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  input  logic                 ser_le,
  output logic [SWALLOW_W-1:0] swallow_cnt,
  output logic [PROG_W-1:0]    prog_cnt,
  output logic [REF_W-1:0]     ref_cnt,
  output logic                 presc_sel,
  output logic                 unprogrammed
);
  localparam int MAIN_W = SWALLOW_W + PROG_W;
  localparam int REFD_W = REF_W + 1;
  localparam int SR_W   = ((MAIN_W > REFD_W) ? MAIN_W : REFD_W) + 1;

  logic [SYNC_STAGES:0][2:0] pipe;
  logic [2:0]                cur, prev;
  logic                      shift_rise, le_rise;
  logic [SR_W-1:0]           sr;
  logic                      ctrl_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-1:0], {ser_clk, ser_data, ser_le}};

  assign cur        = pipe[SYNC_STAGES-1];
  assign prev       = pipe[SYNC_STAGES];
  assign shift_rise = cur[2] & ~prev[2];
  assign le_rise    = cur[0] & ~prev[0];
  assign ctrl_bit   = sr[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          sr <= '0;
    else if (shift_rise) sr <= {sr[SR_W-2:0], cur[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      swallow_cnt  <= '0;
      prog_cnt     <= '0;
      ref_cnt      <= '0;
      presc_sel    <= 1'b0;
      unprogrammed <= 1'b1;
    end else if (le_rise) begin
      unprogrammed <= 1'b0;
      if (!ctrl_bit) {prog_cnt, swallow_cnt} <= sr[MAIN_W:1];
      else           {presc_sel, ref_cnt}    <= sr[REFD_W:1];
    end
endmodule

module serial_loader_checks #(
  parameter int MAIN_W = 18,
  parameter int REFD_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              le_rise,
  input logic              ctrl_bit,
  input logic [MAIN_W-1:0] main_word,
  input logic [REFD_W-1:0] ref_word,
  input logic              unprogrammed
);
  AST_HOLD_MAIN_NO_LE: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(main_word)); // R5
  AST_HOLD_REF_NO_LE: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(ref_word)); // R9
  AST_MAIN_UNTOUCHED_BY_REF: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise && ctrl_bit |=> $stable(main_word)); // R6
  AST_REF_UNTOUCHED_BY_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise && !ctrl_bit |=> $stable(ref_word)); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> !unprogrammed); // R7
  AST_FLAG_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !unprogrammed |=> !unprogrammed); // R7
endmodule

bind serial_loader serial_loader_checks #(.MAIN_W(MAIN_W), .REFD_W(REFD_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .ctrl_bit(ctrl_bit),
  .main_word({prog_cnt, swallow_cnt}), .ref_word({presc_sel, ref_cnt}),
  .unprogrammed(unprogrammed));

// File: tb/test_serial_loader.sv
module test_serial_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [6:0]  swallow_cnt;
  logic [10:0] prog_cnt;
  logic [13:0] ref_cnt;
  logic        presc_sel, unprogrammed;

  int total = 0, bad = 0;
  bit done = 0;
  logic [6:0]  e_sw;
  logic [10:0] e_prog;
  logic [13:0] e_ref;
  logic        e_ps, e_unp;

  always #2.5 clk = ~clk;

  serial_loader i_serial_loader (.*);

  localparam logic [18:0] VEC [6] = '{
    {11'd16,   7'd0,   1'b0},
    {3'b000, 1'b1, 14'h3FFF, 1'b1},
    {11'h7FF,  7'h7F,  1'b0},
    {3'b000, 1'b0, 14'd8,    1'b1},
    {11'd1000, 7'd37,  1'b0},
    {3'b000, 1'b1, 14'd12345, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, swallow_cnt, e_sw);
    chk(req, prog_cnt, e_prog);
    chk(req, ref_cnt, e_ref);
    chk(req, presc_sel, e_ps);
    chk(req, unprogrammed, e_unp);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    ser_data = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(4);
  endtask

  task automatic shift_word(logic [18:0] w);
    int len = w[0] ? 16 : 19;
    for (int i = len - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    wait_clk(4);
    ser_le = 1'b0;
    wait_clk(4);
  endtask

  task automatic model(logic [18:0] w);
    e_unp = 1'b0;
    if (!w[0]) {e_prog, e_sw} = w[18:1];
    else       {e_ps, e_ref}  = w[15:1];
  endtask

  task automatic model_reset();
    e_sw = '0; e_prog = '0; e_ref = '0; e_ps = 1'b0; e_unp = 1'b1;
  endtask

  initial begin
    model_reset();
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check_all("R1 reset");

    foreach (VEC[k]) begin
      shift_word(VEC[k]);
      strobe();
      model(VEC[k]);
      check_all(VEC[k][0] ? "R4 ref load / R2 / R6" : "R3 main load / R2 / R6");
    end

    // R5: shift without strobe, outputs unchanged
    shift_word({11'd555, 7'd99, 1'b0});
    check_all("R5 shift without strobe");

    // R8: extra leading bits discarded
    for (int j = 0; j < 6; j++) shift_bit(1'b1);
    shift_word({11'd300, 7'd5, 1'b0});
    strobe();
    model({11'd300, 7'd5, 1'b0});
    check_all("R8 extra bits dropped");

    // R9: strobe held high while shifting does not reload
    ser_le = 1'b1;
    wait_clk(4);
    shift_word({3'b000, 1'b0, 14'd777, 1'b1});
    check_all("R9 strobe held high");
    ser_le = 1'b0;
    wait_clk(6);
    check_all("R9 strobe falling");

    // R7 and R1: reset again, flag returns, then clears on a reference load
    rst_n = 1'b0;
    wait_clk(2);
    model_reset();
    check_all("R1 second reset");
    rst_n = 1'b1;
    wait_clk(3);
    shift_word({3'b000, 1'b1, 14'd9, 1'b1});
    strobe();
    model({3'b000, 1'b1, 14'd9, 1'b1});
    check_all("R7 flag clears on first load");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule